// File: doc/BRIEF.md
# Run-Mode Clock Source Switch Controller

This controller chooses which of three oscillator sources feeds the system clock while the device is running. The three sources are a slow internal RC source, a fast internal path and a primary external oscillator that may use a PLL. It drives the clock-multiplexer select and the enable of each oscillator. It also runs the start-up and PLL settling timers and reports two status flags: the fast internal path is stable, and the primary start-up is done. The whole block is modelled synchronously in one reference clock domain. The oscillators and the glitch-free multiplexer cells sit outside it.

Software writes the run-mode bit, the frequency field and the alternate-source bit; the controller only reads these inputs and never writes back to them. Any request for a new source keeps the system on the current source while the new one starts. For the internal path, the switch happens once the path reports stable. For the primary path, it happens once a start-up count of primary-oscillator ticks has run, followed by a PLL settling count of reference ticks when the PLL is in use. The select output moves in a single register step, so no intermediate select value ever appears.

Top module: `clk_src_switch`

## Requirements
- R1: During and after reset, `mux_sel` is 2'b00 (slow RC), `fast_ok`, `pri_ok`, `pri_en` and `pll_on` are 0, both counters read 0 and `slow_en` is 1.
- R2: With `freq_sel` all zero and `alt_src` clear, `fast_en` is 0, `fast_ok` stays 0 and `mux_sel` stays 2'b00 even while `fast_stable` is high.
- R3: A nonzero `freq_sel`, or a set `alt_src`, raises `fast_en` at once. `fast_ok` sets, and `mux_sel` moves from 2'b00 to 2'b01, one clock after `fast_stable` is first sampled high. Before that, both hold their old values.
- R4: If the fast path is already enabled and stable, `fast_ok` stays 1 with no gap for as long as the select remains internal, including when a primary request is raised and then withdrawn.
- R5: Clearing `int_run` (primary requested) raises `pri_en` one clock later, plus `pll_on` when `pll_use` is set. `mux_sel` keeps its internal value while the primary source starts.
- R6: `sut_cnt` advances only on clocks with `pri_tick` high. The select does not reach the primary source before SUT_CYCLES (default 1024) ticks have been counted.
- R7: With `pll_use` set, once the start-up count is complete, `pll_cnt` advances on each `ref_tick` and must reach PLL_TICKS before the switch. It does not advance while `ref_tick` is low or while the start-up count is still running.
- R8: When the primary source is ready, then on the next clock `mux_sel` becomes 2'b10, `pri_ok` sets, `fast_ok` clears and both counters return to 0, all in the same cycle.
- R9: Setting `int_run` before the switch completes clears both counters on the next clock and keeps `mux_sel` internal. A later request counts again from zero.
- R10: `slow_en` is 1 whenever the select is internal. While on the primary source it equals `wdt_en | fscm_en`.
- R11: `mux_sel` only takes the values 2'b00, 2'b01 and 2'b10, and it moves from one source to the next in a single clock with no intermediate value.
- R12: Setting `int_run` while running on the primary source returns `mux_sel` to the internal choice on the next clock. On that same clock `pri_ok` and `pri_en` clear, and `fast_ok` reflects the fast path again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| int_run | input | 1 | 1 = internal run requested, 0 = primary run requested |
| freq_sel | input | FSEL_W | Fast-path frequency field; zero leaves the fast path off |
| alt_src | input | 1 | Alternate-source bit; also turns the fast path on |
| wdt_en | input | 1 | Watchdog enabled |
| fscm_en | input | 1 | Fail-safe clock monitor enabled |
| pll_use | input | 1 | Primary path goes through the PLL |
| fast_stable | input | 1 | Fast internal path reports stable |
| pri_tick | input | 1 | One pulse per primary-oscillator cycle |
| ref_tick | input | 1 | PLL settling time base pulse |
| mux_sel | output | 2 | 00 slow RC, 01 fast internal, 10 primary |
| slow_en | output | 1 | Slow RC oscillator enable |
| fast_en | output | 1 | Fast internal path enable |
| pri_en | output | 1 | Primary oscillator enable |
| pll_on | output | 1 | PLL enable |
| sut_cnt | output | SUT_W | Start-up timer value |
| pll_cnt | output | PLL_W | PLL settling timer value |
| fast_ok | output | 1 | Fast internal path stable flag |
| pri_ok | output | 1 | Primary start-up done flag |

## Verification
The primary request is tried in several ways. The plain start-up request shows whether the switch waits for exactly the full tick count: it is checked one tick short of the count, at the count, and across idle clocks without ticks. The PLL request, with `ref_tick` paused partway, separates counting reference ticks from counting clocks, and shows whether the settling count starts only after the start-up count. A request withdrawn partway and then raised again shows whether the counters restart from zero and whether the fast flag survives. A return from the primary source and both enable combinations for the slow source tell apart the select, flag and enable updates that must happen in the same clock.

// File: rtl/clksw_pkg.sv
package clksw_pkg;

  typedef enum logic [1:0] {
    SEL_SLOW = 2'b00,
    SEL_FAST = 2'b01,
    SEL_PRI  = 2'b10
  } clk_sel_e;

  typedef enum logic [1:0] {
    ST_INT  = 2'b00,
    ST_WAIT = 2'b01,
    ST_PRI  = 2'b10
  } run_st_e;

  // internal source choice: fast path only once it is enabled and stable
  function automatic clk_sel_e internal_sel_f(input logic fast_live);
    return fast_live ? SEL_FAST : SEL_SLOW;
  endfunction

  // primary readiness: start-up done, then PLL done when the PLL is used
  function automatic logic pri_ready_f(input logic sut_done, input logic pll_done,
                                       input logic pll_use);
    return sut_done && (!pll_use || pll_done);
  endfunction

endpackage

// File: rtl/clksw_fast_path.sv
module clksw_fast_path #(
  parameter int FSEL_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [FSEL_W-1:0] freq_sel,
  input  logic              alt_src,
  input  logic              fast_stable,
  input  logic              pri_next,
  output logic              fast_en,
  output logic              fast_live,
  output logic              fast_ok
);

  assign fast_en   = (freq_sel != '0) || alt_src;
  assign fast_live = fast_en && fast_stable;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fast_ok <= 1'b0;
    else        fast_ok <= fast_live && !pri_next;
  end

endmodule

// File: rtl/clksw_pri_timer.sv
module clksw_pri_timer #(
  parameter int SUT_CYCLES = 1024,
  parameter int PLL_TICKS  = 64,
  localparam int SUT_W = $clog2(SUT_CYCLES + 1),
  localparam int PLL_W = $clog2(PLL_TICKS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hold,
  input  logic             pri_tick,
  input  logic             ref_tick,
  input  logic             pll_use,
  output logic [SUT_W-1:0] sut_cnt,
  output logic [PLL_W-1:0] pll_cnt,
  output logic             sut_done,
  output logic             pll_done,
  output logic             src_ready
);
  import clksw_pkg::*;

  localparam logic [SUT_W-1:0] SUT_LIM = SUT_W'(SUT_CYCLES);
  localparam logic [PLL_W-1:0] PLL_LIM = PLL_W'(PLL_TICKS);

  logic sut_step, pll_step;

  assign sut_done  = (sut_cnt == SUT_LIM);
  assign pll_done  = (pll_cnt == PLL_LIM);
  assign sut_step  = pri_tick && !sut_done;
  assign pll_step  = pll_use && sut_done && ref_tick && !pll_done;
  assign src_ready = pri_ready_f(sut_done, pll_done, pll_use);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sut_cnt <= '0;
      pll_cnt <= '0;
    end else if (!hold) begin
      sut_cnt <= '0;
      pll_cnt <= '0;
    end else begin
      if (sut_step) sut_cnt <= sut_cnt + 1'b1;
      if (pll_step) pll_cnt <= pll_cnt + 1'b1;
    end
  end

endmodule

// File: rtl/clksw_run_fsm.sv
module clksw_run_fsm (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 int_run,
  input  logic                 src_ready,
  input  logic                 fast_live,
  output clksw_pkg::run_st_e   state,
  output clksw_pkg::clk_sel_e  sel_q,
  output logic                 hold,
  output logic                 pri_next
);
  import clksw_pkg::*;

  run_st_e  state_d;
  clk_sel_e sel_d;

  always_comb begin
    state_d = state;
    unique case (state)
      ST_INT:  if (!int_run) state_d = ST_WAIT;
      ST_WAIT: if (int_run) state_d = ST_INT;
               else if (src_ready) state_d = ST_PRI;
      ST_PRI:  if (int_run) state_d = ST_INT;
      default: state_d = ST_INT;
    endcase
  end

  assign pri_next = (state_d == ST_PRI);
  assign hold     = (state == ST_WAIT) && (state_d == ST_WAIT);
  assign sel_d    = pri_next ? SEL_PRI : internal_sel_f(fast_live);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_INT;
      sel_q <= SEL_SLOW;
    end else begin
      state <= state_d;
      sel_q <= sel_d;
    end
  end

endmodule

// File: rtl/clk_src_switch.sv
module clk_src_switch #(
  parameter int FSEL_W     = 3,
  parameter int SUT_CYCLES = 1024,
  parameter int PLL_TICKS  = 64,
  localparam int SUT_W = $clog2(SUT_CYCLES + 1),
  localparam int PLL_W = $clog2(PLL_TICKS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              int_run,
  input  logic [FSEL_W-1:0] freq_sel,
  input  logic              alt_src,
  input  logic              wdt_en,
  input  logic              fscm_en,
  input  logic              pll_use,
  input  logic              fast_stable,
  input  logic              pri_tick,
  input  logic              ref_tick,
  output logic [1:0]        mux_sel,
  output logic              slow_en,
  output logic              fast_en,
  output logic              pri_en,
  output logic              pll_on,
  output logic [SUT_W-1:0]  sut_cnt,
  output logic [PLL_W-1:0]  pll_cnt,
  output logic              fast_ok,
  output logic              pri_ok
);
  import clksw_pkg::*;

  run_st_e  state;
  clk_sel_e sel_q;
  logic     hold, pri_next, fast_live;
  logic     sut_done, pll_done, src_ready;

  clksw_fast_path #(.FSEL_W(FSEL_W)) u_fast (
    .clk(clk), .rst_n(rst_n), .freq_sel(freq_sel), .alt_src(alt_src),
    .fast_stable(fast_stable), .pri_next(pri_next),
    .fast_en(fast_en), .fast_live(fast_live), .fast_ok(fast_ok)
  );

  clksw_pri_timer #(.SUT_CYCLES(SUT_CYCLES), .PLL_TICKS(PLL_TICKS)) u_tmr (
    .clk(clk), .rst_n(rst_n), .hold(hold), .pri_tick(pri_tick),
    .ref_tick(ref_tick), .pll_use(pll_use), .sut_cnt(sut_cnt),
    .pll_cnt(pll_cnt), .sut_done(sut_done), .pll_done(pll_done),
    .src_ready(src_ready)
  );

  clksw_run_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .int_run(int_run), .src_ready(src_ready),
    .fast_live(fast_live), .state(state), .sel_q(sel_q), .hold(hold),
    .pri_next(pri_next)
  );

  assign mux_sel = sel_q;
  assign pri_ok  = (state == ST_PRI);
  assign pri_en  = (state != ST_INT);
  assign pll_on  = pri_en && pll_use;
  assign slow_en = (sel_q != SEL_PRI) || wdt_en || fscm_en;

endmodule

// File: rtl/clksw_chk.sv
module clksw_chk #(
  parameter int SUT_CYCLES = 1024,
  parameter int PLL_TICKS  = 64,
  localparam int SUT_W = $clog2(SUT_CYCLES + 1),
  localparam int PLL_W = $clog2(PLL_TICKS + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             int_run,
  input logic             pll_use,
  input logic             fast_stable,
  input logic             fast_en,
  input logic [1:0]       mux_sel,
  input logic             slow_en,
  input logic             pri_en,
  input logic [SUT_W-1:0] sut_cnt,
  input logic [PLL_W-1:0] pll_cnt,
  input logic             fast_ok,
  input logic             pri_ok
);

  // R11
  sel_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mux_sel != 2'b11);

  // R2
  fast_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fast_en |=> !fast_ok);

  // R3
  fast_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fast_ok) |-> ($past(fast_stable) && $past(fast_en)));

  // R6
  sut_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mux_sel == 2'b10 && $past(mux_sel) != 2'b10) |-> $past(sut_cnt) == SUT_W'(SUT_CYCLES));

  // R7
  pll_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(pri_ok) && $past(pll_use)) |-> $past(pll_cnt) == PLL_W'(PLL_TICKS));

  // R8
  switch_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pri_ok) |-> (mux_sel == 2'b10 && !fast_ok && sut_cnt == '0));

  // R9
  withdraw_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pri_en && int_run) |=> (mux_sel != 2'b10 && !pri_ok && sut_cnt == '0 && pll_cnt == '0));

  // R10
  slow_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pri_ok |-> slow_en);

endmodule

bind clk_src_switch clksw_chk #(.SUT_CYCLES(SUT_CYCLES), .PLL_TICKS(PLL_TICKS)) u_chk (.*);

// File: tb/sim_clk_src_switch.sv
module sim_clk_src_switch;

  localparam int SUT = 1024;
  localparam int PLLT = 40;
  localparam int SW = $clog2(SUT + 1);
  localparam int PW = $clog2(PLLT + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic int_run = 1'b1, alt_src = 1'b0, wdt_en = 1'b0, fscm_en = 1'b0;
  logic pll_use = 1'b0, fast_stable = 1'b0, pri_tick = 1'b0, ref_tick = 1'b0;
  logic [2:0] freq_sel = 3'd0;
  logic [1:0] mux_sel;
  logic slow_en, fast_en, pri_en, pll_on, fast_ok, pri_ok;
  logic [SW-1:0] sut_cnt;
  logic [PW-1:0] pll_cnt;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  clk_src_switch #(.FSEL_W(3), .SUT_CYCLES(SUT), .PLL_TICKS(PLLT)) u0 (
    .clk(clk), .rst_n(rst_n), .int_run(int_run), .freq_sel(freq_sel),
    .alt_src(alt_src), .wdt_en(wdt_en), .fscm_en(fscm_en), .pll_use(pll_use),
    .fast_stable(fast_stable), .pri_tick(pri_tick), .ref_tick(ref_tick),
    .mux_sel(mux_sel), .slow_en(slow_en), .fast_en(fast_en), .pri_en(pri_en),
    .pll_on(pll_on), .sut_cnt(sut_cnt), .pll_cnt(pll_cnt), .fast_ok(fast_ok),
    .pri_ok(pri_ok)
  );

  task automatic check(input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pri_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) pri_tick = 1'b1;
      @(negedge clk) pri_tick = 1'b0;
    end
  endtask

  task automatic t_reset;
    idle(2);
    check("R1 sel in reset", mux_sel, 0);
    rst_n = 1'b1;
    idle(2);
    check("R1 sel", mux_sel, 0);
    check("R1 flags", {fast_ok, pri_ok, pri_en, pll_on}, 0);
    check("R1 counters", sut_cnt + pll_cnt, 0);
    check("R1 slow_en", slow_en, 1);
  endtask

  task automatic t_fast_off;
    fast_stable = 1'b1;
    idle(3);
    check("R2 fast_en", fast_en, 0);
    check("R2 fast_ok", fast_ok, 0);
    check("R2 sel", mux_sel, 0);
  endtask

  task automatic t_fast_on;
    fast_stable = 1'b0;
    alt_src = 1'b1;
    #1 check("R3 alt_src enables", fast_en, 1);
    idle(1);
    alt_src = 1'b0;
    freq_sel = 3'd5;
    #1 check("R3 freq enables", fast_en, 1);
    idle(4);
    check("R3 no flag before stable", fast_ok, 0);
    check("R3 sel slow before stable", mux_sel, 0);
    fast_stable = 1'b1;
    #1 check("R3 flag not yet", fast_ok, 0);
    idle(1);
    check("R3 flag one clock after stable", fast_ok, 1);
    check("R3 sel fast", mux_sel, 1);
  endtask

  task automatic t_pri_plain;
    int_run = 1'b0;
    idle(1);
    check("R5 pri_en", pri_en, 1);
    check("R5 pll_on off", pll_on, 0);
    check("R5 sel stays internal", mux_sel, 1);
    pri_ticks(SUT - 1);
    check("R6 count one short", sut_cnt, SUT - 1);
    idle(5);
    check("R6 no count without tick", sut_cnt, SUT - 1);
    check("R6 sel before full count", mux_sel, 1);
    check("R4 fast_ok during start-up", fast_ok, 1);
    pri_ticks(1);
    check("R6 count full", sut_cnt, SUT);
    check("R11 sel still fast", mux_sel, 1);
    idle(1);
    check("R8 sel primary", mux_sel, 2);
    check("R8 pri_ok", pri_ok, 1);
    check("R8 fast_ok cleared", fast_ok, 0);
    check("R8 counter cleared", sut_cnt, 0);
    check("R10 slow off", slow_en, 0);
  endtask

  task automatic t_back;
    int_run = 1'b1;
    idle(1);
    check("R12 sel internal", mux_sel, 1);
    check("R12 pri_ok", pri_ok, 0);
    check("R12 pri_en", pri_en, 0);
    check("R12 fast_ok back", fast_ok, 1);
    check("R10 slow on", slow_en, 1);
  endtask

  task automatic t_withdraw;
    int_run = 1'b0;
    idle(1);
    pri_ticks(300);
    check("R9 partial count", sut_cnt, 300);
    int_run = 1'b1;
    idle(1);
    check("R9 counter cleared", sut_cnt, 0);
    check("R9 sel internal", mux_sel, 1);
    check("R4 fast_ok no gap", fast_ok, 1);
    int_run = 1'b0;
    idle(1);
    pri_ticks(1);
    check("R9 restart from zero", sut_cnt, 1);
    int_run = 1'b1;
    idle(2);
  endtask

  task automatic t_pll;
    wdt_en = 1'b1;
    pll_use = 1'b1;
    ref_tick = 1'b1;
    int_run = 1'b0;
    idle(1);
    check("R5 pll_on", pll_on, 1);
    pri_ticks(SUT);
    check("R7 pll idle during start-up", pll_cnt, 0);
    idle(10);
    check("R7 pll counting", pll_cnt, 10);
    ref_tick = 1'b0;
    idle(5);
    check("R7 pll holds without ref_tick", pll_cnt, 10);
    ref_tick = 1'b1;
    idle(PLLT - 10);
    check("R7 pll full", pll_cnt, PLLT);
    check("R7 sel waits for pll", mux_sel, 1);
    idle(1);
    check("R7 sel primary after pll", mux_sel, 2);
    check("R10 slow kept by watchdog", slow_en, 1);
    wdt_en = 1'b0;
    fscm_en = 1'b1;
    #1 check("R10 slow kept by monitor", slow_en, 1);
    fscm_en = 1'b0;
    #1 check("R10 slow off on primary", slow_en, 0);
    int_run = 1'b1;
    idle(1);
    check("R12 back after pll", mux_sel, 1);
  endtask

  initial begin
    t_reset();
    t_fast_off();
    t_fast_on();
    t_pri_plain();
    t_back();
    t_withdraw();
    t_pll();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule